// File: doc/BRIEF.md
# Variable-Length Field Comparator

This block compares two character fields held in storage and reports how they relate. A compare begins with a start pulse that gives the units (lowest-order) address of each field. The block then reads one character from each field per cycle, moving from the units position toward the high-order end, and stops at the first word mark it finds in either field. Characters are ordered by a business collating sequence rather than by their binary code. When the compare ends, the block drives four indicators (equal, unequal, high, low) that a branch unit can test.

Each storage character is 7 bits. Bit 6 is the word mark, bits 5:4 are the zone and bits 3:0 are the numeric part. The storage read port is combinational: the block presents an address and sees that address's character in the same cycle. A chained compare continues from the addresses where the previous compare stopped and carries its result forward, so a long field can be compared as a series of shorter pieces. A small external path lets another unit clear or load the indicators while the comparator is idle.

Top module: `field_compare`

## Requirements
- R1: After reset, `busy`, `done` and all four indicators are low.
- R2: When idle, a `start` pulse loads the two field addresses. `aAddr`/`bAddr` present one position per cycle, starting at the given units addresses and decreasing by one each cycle. `busy` is high while the scan runs. `done` is a one-cycle pulse, high in the cycle after the terminating position was examined, so a scan of N positions ends N cycles after the start edge. A `start` received while busy is ignored.
- R3: A character with bit 6 set (word mark) in either field ends the compare, and the position that carries it is itself compared. When the A field is longer, A positions beyond the B word mark are never read.
- R4: When the A word mark appears at a position where B has no word mark (B longer), the result is unequal with high set, whatever the characters are.
- R5: Two characters are equal only if all 6 code bits match, zone bits included. Plus-zero 0x3A and digit zero 0x0A are unequal.
- R6: Collating order, lowest first: blank (0x00); every other code not listed below, in ascending code order; letters A–I (zone 11, numeric 1–9); letters J–R (zone 10, numeric 1–9); letters S–Z (zone 01, numeric 2–9); digit 0 (0x0A); digits 1–9 (0x01–0x09).
- R7: Within one compare, the highest-order position whose characters differ decides the result. High means the B character ranks above the A character; low means it ranks below.
- R8: With `chainIn` high at start, the supplied addresses are ignored and the scan continues from the addresses where the previous compare stopped. If the indicators already show an unequal result, that result is kept. Otherwise the new scan decides the result.
- R9: When a compare completes, exactly one of `eqInd`, `hiInd` and `loInd` is set, and `neInd` equals `hiInd | loInd`.
- R10: While idle, `extClear` turns all indicators off, taking priority over `extLoad`. `extLoad` sets the indicators from `extRel`: 01 gives high, 10 gives low, and any other value gives equal. Both inputs are ignored while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a compare (ignored while busy) |
| chainIn | input | 1 | Continue from the previous compare's addresses and result |
| aStart | input | ADDR_W | Units address of the A field |
| bStart | input | ADDR_W | Units address of the B field |
| aAddr | output | ADDR_W | Current A read address |
| bAddr | output | ADDR_W | Current B read address |
| aChar | input | 7 | Character at aAddr (bit 6 word mark) |
| bChar | input | 7 | Character at bAddr (bit 6 word mark) |
| extClear | input | 1 | Turn all indicators off (idle only) |
| extLoad | input | 1 | Load the indicators from extRel (idle only) |
| extRel | input | 2 | Relation to load: 01 high, 10 low, other values equal |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle completion pulse |
| eqInd | output | 1 | Equal indicator |
| neInd | output | 1 | Unequal indicator |
| hiInd | output | 1 | High indicator (B above A) |
| loInd | output | 1 | Low indicator (B below A) |

## Verification
The assertions check properties that must hold on every cycle:
- the one-cycle shape of `done`;
- the one-per-cycle decrement of both addresses;
- the one-hot indicator state after completion;
- forcing high when B is longer;
- freezing the indicators against the external path during a scan;
- keeping a locked chained result.

The bench scenarios cover what the assertions cannot: the collating order itself, equality that depends on zone bits, and which position decides the result. To do this the bench sweeps every pair of character codes and builds its own rank table. It also checks scan lengths for mixed field lengths and composite results across chained compares.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;
  localparam int CODE_W = 6;
  localparam int RANK_W = 7;

  typedef enum logic [1:0] {
    REL_EQ   = 2'd0,
    REL_HIGH = 2'd1,
    REL_LOW  = 2'd2
  } rel_e;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
  } strobe_t;
endpackage

// File: rtl/fcmp_collate.sv
module fcmp_collate
  import fcmp_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [RANK_W-1:0] rank
);
  logic [1:0] zone;
  logic [3:0] num;
  logic [RANK_W-1:0] numExt;
  logic numDigit;

  assign zone = code[5:4];
  assign num = code[3:0];
  assign numExt = RANK_W'(num);
  assign numDigit = (num >= 4'd1) && (num <= 4'd9);

  // Rank layout: blank 0, specials 1..64, A-I 65..73, J-R 74..82,
  // S-Z 83..90, digit zero 91, digits 1..9 92..100
  always_comb begin
    if (code == '0) rank = '0;
    else if (zone == 2'b00 && numDigit) rank = RANK_W'(91) + numExt;
    else if (zone == 2'b00 && num == 4'd10) rank = RANK_W'(91);
    else if (zone == 2'b11 && numDigit) rank = RANK_W'(64) + numExt;
    else if (zone == 2'b10 && numDigit) rank = RANK_W'(73) + numExt;
    else if (zone == 2'b01 && numDigit && num != 4'd1) rank = RANK_W'(81) + numExt;
    else rank = RANK_W'(1) + RANK_W'(code);
  end
endmodule

// File: rtl/fcmp_ctrl.sv
module fcmp_ctrl
  import fcmp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  logic    endPos,
  output strobe_t strb,
  output logic    busy,
  output logic    done
);
  typedef enum logic {ST_IDLE, ST_RUN} state_e;
  state_e state;

  always_comb begin
    strb.load = (state == ST_IDLE) && start;
    strb.step = (state == ST_RUN);
    strb.finish = (state == ST_RUN) && endPos;
  end

  assign busy = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done <= 1'b0;
    end else begin
      done <= strb.finish;
      if (strb.load) state <= ST_RUN;
      else if (strb.finish) state <= ST_IDLE;
    end
  end

  // R2: completion is a single-cycle pulse
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R2: a scan keeps running until a terminating position, start is ignored
  a_r2_run_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !endPos) |=> (busy && !done));
endmodule

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int CHAR_W = CODE_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              busy,
  input  logic              chainIn,
  input  logic [ADDR_W-1:0] aStart,
  input  logic [ADDR_W-1:0] bStart,
  input  logic [CHAR_W-1:0] aChar,
  input  logic [CHAR_W-1:0] bChar,
  input  logic              extClear,
  input  logic              extLoad,
  input  logic [1:0]        extRel,
  output logic [ADDR_W-1:0] aAddr,
  output logic [ADDR_W-1:0] bAddr,
  output logic              endPos,
  output logic              eqInd,
  output logic              neInd,
  output logic              hiInd,
  output logic              loInd
);
  localparam int WM_BIT = CHAR_W - 1;

  logic [ADDR_W-1:0] aPtr, bPtr;
  rel_e rel, relNext, indRel, priorRel, extDecoded;
  logic locked, indValid;
  logic [CODE_W-1:0] codes [2];
  logic [RANK_W-1:0] ranks [2];
  logic aWm, bWm;

  assign codes[0] = aChar[CODE_W-1:0];
  assign codes[1] = bChar[CODE_W-1:0];
  assign aWm = aChar[WM_BIT];
  assign bWm = bChar[WM_BIT];

  for (genvar g = 0; g < 2; g++) begin : g_col
    fcmp_collate u_col (.code(codes[g]), .rank(ranks[g]));
  end

  assign aAddr = aPtr;
  assign bAddr = bPtr;
  assign endPos = aWm || bWm;
  assign priorRel = indValid ? indRel : REL_EQ;

  always_comb begin
    relNext = rel;
    if (!locked) begin
      if (aWm && !bWm) relNext = REL_HIGH;
      else if (codes[0] != codes[1])
        relNext = (ranks[1] > ranks[0]) ? REL_HIGH : REL_LOW;
    end
  end

  always_comb begin
    case (extRel)
      2'b01: extDecoded = REL_HIGH;
      2'b10: extDecoded = REL_LOW;
      default: extDecoded = REL_EQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aPtr <= '0;
      bPtr <= '0;
      rel <= REL_EQ;
      locked <= 1'b0;
      indRel <= REL_EQ;
      indValid <= 1'b0;
    end else begin
      if (strb.load) begin
        if (!chainIn) begin
          aPtr <= aStart;
          bPtr <= bStart;
        end
        rel <= chainIn ? priorRel : REL_EQ;
        locked <= chainIn && (priorRel != REL_EQ);
      end else if (strb.step) begin
        aPtr <= aPtr - 1'b1;
        bPtr <= bPtr - 1'b1;
        rel <= relNext;
      end
      if (strb.finish) begin
        indRel <= relNext;
        indValid <= 1'b1;
      end else if (!busy) begin
        if (extClear) indValid <= 1'b0;
        else if (extLoad) begin
          indValid <= 1'b1;
          indRel <= extDecoded;
        end
      end
    end
  end

  assign eqInd = indValid && (indRel == REL_EQ);
  assign hiInd = indValid && (indRel == REL_HIGH);
  assign loInd = indValid && (indRel == REL_LOW);
  assign neInd = indValid && (indRel != REL_EQ);

  // R9: one relation indicator at completion, unequal tracks high/low
  a_r9_one_result: assert property (@(posedge clk) disable iff (!rstN)
    strb.finish |=> ($onehot({eqInd, hiInd, loInd}) && (neInd == (hiInd || loInd))));
  // R2: both addresses move down by one per scanned position
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.finish) |=>
      ((aAddr == ADDR_W'($past(aAddr) - 1'b1)) && (bAddr == ADDR_W'($past(bAddr) - 1'b1))));
  // R4: A word mark without B word mark forces high
  a_r4_b_longer: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && aWm && !bWm && !locked) |=> hiInd);
  // R10: indicators frozen against the external path during a scan
  a_r10_busy_freeze: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strb.finish) |=> $stable({indValid, indRel}));
  // R8: a chained compare that starts unequal keeps its relation
  a_r8_chain_keep: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && locked) |=> $stable(indRel));
endmodule

// File: rtl/field_compare.sv
module field_compare
  import fcmp_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              chainIn,
  input  logic [ADDR_W-1:0] aStart,
  input  logic [ADDR_W-1:0] bStart,
  output logic [ADDR_W-1:0] aAddr,
  output logic [ADDR_W-1:0] bAddr,
  input  logic [6:0]        aChar,
  input  logic [6:0]        bChar,
  input  logic              extClear,
  input  logic              extLoad,
  input  logic [1:0]        extRel,
  output logic              busy,
  output logic              done,
  output logic              eqInd,
  output logic              neInd,
  output logic              hiInd,
  output logic              loInd
);
  strobe_t strb;
  logic endPos;

  fcmp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .endPos(endPos),
    .strb(strb), .busy(busy), .done(done)
  );

  fcmp_datapath #(.ADDR_W(ADDR_W), .CHAR_W(7)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .busy(busy), .chainIn(chainIn),
    .aStart(aStart), .bStart(bStart), .aChar(aChar), .bChar(bChar),
    .extClear(extClear), .extLoad(extLoad), .extRel(extRel),
    .aAddr(aAddr), .bAddr(bAddr), .endPos(endPos),
    .eqInd(eqInd), .neInd(neInd), .hiInd(hiInd), .loInd(loInd)
  );
endmodule

// File: tb/field_compare_bench.sv
module field_compare_bench;
  localparam int AW = 12;
  localparam int A_UNITS = 20;
  localparam int B_UNITS = 50;

  logic clk = 0;
  logic rstN = 0;
  logic start = 0, chainIn = 0, extClear = 0, extLoad = 0;
  logic [1:0] extRel = 0;
  logic [AW-1:0] aStartI = 0, bStartI = 0;
  logic [AW-1:0] aAddr, bAddr;
  logic [6:0] aChar, bChar;
  logic busy, done, eqInd, neInd, hiInd, loInd;
  logic [6:0] mem [64];
  int rk [64];
  int checks = 0, errors = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  assign aChar = mem[aAddr[5:0]];
  assign bChar = mem[bAddr[5:0]];

  field_compare #(.ADDR_W(AW)) u_field_compare (
    .clk(clk), .rstN(rstN), .start(start), .chainIn(chainIn),
    .aStart(aStartI), .bStart(bStartI), .aAddr(aAddr), .bAddr(bAddr),
    .aChar(aChar), .bChar(bChar), .extClear(extClear), .extLoad(extLoad),
    .extRel(extRel), .busy(busy), .done(done), .eqInd(eqInd),
    .neInd(neInd), .hiInd(hiInd), .loInd(loInd)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // 0 equal, 1 high, 2 low, 3 none, 4 malformed
  function automatic int gotRel();
    if ($countones({eqInd, hiInd, loInd}) > 1 || neInd != (hiInd || loInd)) return 4;
    if (eqInd) return 0;
    if (hiInd) return 1;
    if (loInd) return 2;
    return 3;
  endfunction

  function automatic int nextRand(input int m);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'(lfsr) % m;
  endfunction

  // collating table built from the listed order, independent of code arithmetic
  task automatic buildRanks();
    bit used [64];
    int pos = 0;
    for (int c = 0; c < 64; c++) used[c] = 0;
    used[0] = 1;
    for (int n = 1; n <= 9; n++) begin
      used[n] = 1; used[48 + n] = 1; used[32 + n] = 1;
      if (n >= 2) used[16 + n] = 1;
    end
    used[10] = 1;
    rk[0] = pos++;
    for (int c = 1; c < 64; c++) if (!used[c]) rk[c] = pos++;
    for (int n = 1; n <= 9; n++) rk[48 + n] = pos++;
    for (int n = 1; n <= 9; n++) rk[32 + n] = pos++;
    for (int n = 2; n <= 9; n++) rk[16 + n] = pos++;
    rk[10] = pos++;
    for (int n = 1; n <= 9; n++) rk[n] = pos++;
  endtask

  task automatic clearMem();
    for (int i = 0; i < 64; i++) mem[i] = 7'h00;
  endtask

  function automatic int relOf(input int a, input int b);
    if (a == b) return 0;
    return (rk[b] > rk[a]) ? 1 : 2;
  endfunction

  // reference scan over memory, returns relation and positions examined
  task automatic model(input int aU, input int bU, input int prior, output int rel, output int len);
    rel = prior;
    len = 0;
    for (int i = 0; i < 64; i++) begin
      logic [6:0] a, b;
      a = mem[(aU - i) & 63];
      b = mem[(bU - i) & 63];
      len = i + 1;
      if (prior == 0) begin
        if (a[6] && !b[6]) rel = 1;
        else if (a[5:0] != b[5:0]) rel = relOf(int'(a[5:0]), int'(b[5:0]));
      end
      if (a[6] || b[6]) break;
    end
  endtask

  task automatic runCmp(input logic ch, input int aS, input int bS, output int cyc);
    @(negedge clk);
    start = 1; chainIn = ch; aStartI = AW'(aS); bStartI = AW'(bS);
    @(negedge clk);
    start = 0; chainIn = 0;
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  function automatic int pickCode();
    int pool [8] = '{0, 10, 58, 5, 49, 33, 25, 44};
    return pool[nextRand(8)];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc, rel, len, got;
    buildRanks();
    clearMem();
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1: reset state
    chk(!busy && !done && !eqInd && !neInd && !hiInd && !loInd, "R1 reset",
        {busy, done, eqInd, neInd, hiInd, loInd}, 0);

    // R5 R6 R9: exhaustive one-position sweep
    for (int a = 0; a < 64; a++) begin
      for (int b = 0; b < 64; b++) begin
        clearMem();
        mem[A_UNITS] = {1'b1, 6'(a)};
        mem[B_UNITS] = {1'b1, 6'(b)};
        runCmp(1'b0, A_UNITS, B_UNITS, cyc);
        got = gotRel();
        chk(got == relOf(a, b) && cyc == 1, "R6 R5 R9 pair sweep", got * 1000 + cyc, relOf(a, b) * 1000 + 1);
      end
    end

    // R5: plus-zero against digit zero
    clearMem();
    mem[A_UNITS] = {1'b1, 6'h3A};
    mem[B_UNITS] = {1'b1, 6'h0A};
    runCmp(1'b0, A_UNITS, B_UNITS, cyc);
    chk(neInd && !eqInd, "R5 zone differs", gotRel(), 1);

    // R2 R3 R4 R7: mixed lengths
    for (int t = 0; t < 400; t++) begin
      int la, lb;
      la = 1 + nextRand(6);
      lb = 1 + nextRand(6);
      clearMem();
      for (int i = 0; i < la; i++) mem[A_UNITS - i] = {1'(i == la - 1), 6'(pickCode())};
      for (int i = 0; i < lb; i++) mem[B_UNITS - i] = {1'(i == lb - 1), 6'(pickCode())};
      // A positions beyond a shorter B must not matter
      model(A_UNITS, B_UNITS, 0, rel, len);
      runCmp(1'b0, A_UNITS, B_UNITS, cyc);
      chk(cyc == len, "R2 R3 scan length", cyc, len);
      chk(gotRel() == rel, "R7 R4 R3 field result", gotRel(), rel);
      chk(int'(aAddr) == A_UNITS - len && int'(bAddr) == B_UNITS - len, "R2 final addresses",
          int'(aAddr), A_UNITS - len);
    end

    // R8: chained compares
    for (int t = 0; t < 60; t++) begin
      int l1, l2, r1, r2, n1, n2, expRel;
      l1 = 1 + nextRand(4);
      l2 = 1 + nextRand(4);
      clearMem();
      for (int i = 0; i < l1; i++) begin
        mem[A_UNITS - i] = {1'(i == l1 - 1), 6'(pickCode())};
        mem[B_UNITS - i] = {1'(i == l1 - 1), 6'(pickCode())};
      end
      for (int i = 0; i < l2; i++) begin
        mem[A_UNITS - l1 - i] = {1'(i == l2 - 1), 6'(pickCode())};
        mem[B_UNITS - l1 - i] = {1'(i == l2 - 1), 6'(pickCode())};
      end
      model(A_UNITS, B_UNITS, 0, r1, n1);
      runCmp(1'b0, A_UNITS, B_UNITS, cyc);
      chk(gotRel() == r1, "R8 first piece", gotRel(), r1);
      model(A_UNITS - l1, B_UNITS - l1, r1, r2, n2);
      expRel = r2;
      runCmp(1'b1, 5, 7, cyc);
      chk(cyc == n2, "R8 chained length", cyc, n2);
      chk(gotRel() == expRel, "R8 composite result", gotRel(), expRel);
    end

    // R10: external path while idle
    for (int e = 0; e < 4; e++) begin
      int exp;
      exp = (e == 1) ? 1 : (e == 2) ? 2 : 0;
      @(negedge clk); extLoad = 1; extRel = 2'(e);
      @(negedge clk); extLoad = 0;
      chk(gotRel() == exp, "R10 external load", gotRel(), exp);
    end
    @(negedge clk); extClear = 1; extLoad = 1; extRel = 2'b01;
    @(negedge clk); extClear = 0; extLoad = 0;
    chk(gotRel() == 3, "R10 external clear", gotRel(), 3);

    // R10 R2: external inputs and start ignored during a scan
    clearMem();
    for (int i = 0; i < 6; i++) begin
      mem[A_UNITS - i] = {1'(i == 5), 6'h05};
      mem[B_UNITS - i] = {1'(i == 5), 6'(i == 4 ? 6'h31 : 6'h05)};
    end
    @(negedge clk); extLoad = 1; extRel = 2'b10;
    @(negedge clk); extLoad = 0;
    @(negedge clk); start = 1; aStartI = AW'(A_UNITS); bStartI = AW'(B_UNITS);
    @(negedge clk); start = 0;
    @(negedge clk); extClear = 1; start = 1; aStartI = AW'(3); bStartI = AW'(9);
    @(negedge clk); extClear = 0; start = 0;
    chk(gotRel() == 2 && busy, "R10 ignored while busy", gotRel(), 2);
    cyc = 2;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == 6, "R2 restart ignored", cyc, 6);
    chk(gotRel() == 2, "R7 letter below digit", gotRel(), 2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule